// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a register-transfer datapath that carries out one micro-operation on every clock cycle. A single packed control word sets up the whole cycle. Two source selectors each place a general register, or the external data input, onto an operand bus. An operation field chooses what the ALU does with the two buses. A destination selector picks which register, if any, captures the result.

The register file holds seven general registers. Both operands are read combinationally in the same cycle, and the destination is written on the next rising edge. The ALU result and its zero, sign and carry flags are registered onto the external output every cycle, so the result can be seen there even when no register is written. Sequencing of control words and memory access are the job of surrounding logic.

Top module: `uop_datapath`

## Requirements
- R1: `ctrl_word` is packed from the most significant bit down as source A selector [13:11], source B selector [10:8], destination selector [7:5] and operation code [4:0].
- R2: A source selector value from 1 to 7 places the current contents of register R1 to R7 onto its operand bus.
- R3: A source selector value of 0 places `ext_in` onto that operand bus.
- R4: A destination value from 1 to 7 writes the ALU result into that register on the rising edge. A destination value of 0 leaves every register unchanged.
- R5: On each rising edge outside reset, `ext_out` takes the ALU result of the cycle, whatever the destination value.
- R6: Operation 00010 gives A+B, with carry set on unsigned overflow. Operation 00101 gives A-B, with carry set when A<B (borrow).
- R7: Operation 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A, and 00000 gives A. Each of these clears carry.
- R8: Operation 10000 shifts A right by one bit and 11000 shifts A left by one bit. A zero enters at the vacated end, and carry takes the bit shifted out.
- R9: Every other operation code passes A through unchanged with carry cleared.
- R10: `flag_zero` is 1 exactly when `ext_out` is zero, and `flag_sign` equals the top bit of `ext_out`.
- R11: Synchronous active-high reset clears all registers, `ext_out`, `flag_sign` and `flag_carry`, and sets `flag_zero`.
- R12: A register may be a source and the destination in the same word. The operation then uses the value the register held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 14 | Packed micro-operation control word |
| ext_in | input | 8 | External data, used when a source selector is 0 |
| ext_out | output | 8 | Registered ALU result |
| flag_zero | output | 1 | Registered result-is-zero flag |
| flag_sign | output | 1 | Registered top bit of the result |
| flag_carry | output | 1 | Registered carry, borrow or shifted-out bit |

## Verification
The bound checker checks on every cycle the behaviours visible from ports alone: the reset values, flags that agree with the output, carry cleared for logic and pass operations, and the results of transfer, complement, shift and undefined codes taken from the external input. Register storage, the ignored destination code, same-register read and write, and arithmetic on register contents show up only through the bench's sequences, which read registers back through the output. The bench sweeps every operation code against every source and destination combination, and compares each result against an arithmetic model of the register file.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int SEL_W = 3;
  localparam int OP_W  = 5;
  localparam int CW_W  = 3 * SEL_W + OP_W;

  localparam logic [OP_W-1:0] OP_XFER = 5'b00000;
  localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
  localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
  localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
  localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
  localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
  localparam logic [OP_W-1:0] OP_NOTA = 5'b01110;
  localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
  localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } uop_word_t;
endpackage

// File: rtl/uop_regfile.sv
module uop_regfile #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int NRD   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data
);
  localparam int DEPTH = 2 ** AW;

  // entry 0 is never written: address 0 means "no register"
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && wr_addr != '0) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/uop_opnd_mux.sv
module uop_opnd_mux #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic [AW-1:0] sel,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] ext_val,
  output logic [DW-1:0] bus
);
  assign bus = (sel == '0) ? ext_val : reg_val;
endmodule

// File: rtl/uop_alu.sv
module uop_alu
  import uop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            zero,
  output logic            sign,
  output logic            carry
);
  always_comb begin
    res   = a;
    carry = 1'b0;
    case (op)
      OP_XFER: res = a;
      OP_ADD:  {carry, res} = {1'b0, a} + {1'b0, b};
      OP_SUB:  {carry, res} = {1'b0, a} - {1'b0, b};
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOTA: res = ~a;
      OP_SHR: begin
        res   = {1'b0, a[DW-1:1]};
        carry = a[0];
      end
      OP_SHL: begin
        res   = {a[DW-2:0], 1'b0};
        carry = a[DW-1];
      end
      default: res = a;
    endcase
  end

  assign zero = (res == '0);
  assign sign = res[DW-1];
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [DW-1:0]   ext_in,
  output logic [DW-1:0]   ext_out,
  output logic            flag_zero,
  output logic            flag_sign,
  output logic            flag_carry
);
  localparam int NRD = 2;

  uop_word_t cw;
  assign cw = uop_word_t'(ctrl_word);

  logic [NRD-1:0][SEL_W-1:0] rsel;
  logic [NRD-1:0][DW-1:0]    rval;
  logic [NRD-1:0][DW-1:0]    opnd;

  assign rsel[0] = cw.src_a;
  assign rsel[1] = cw.src_b;

  logic [DW-1:0] alu_res;
  logic          alu_z, alu_s, alu_c;

  uop_regfile #(.DW(DW), .AW(SEL_W), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rsel),
    .rd_data (rval),
    .wr_en   (cw.dst != '0),
    .wr_addr (cw.dst),
    .wr_data (alu_res)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_bus
    uop_opnd_mux #(.DW(DW), .AW(SEL_W)) u_mux (
      .sel     (rsel[g]),
      .reg_val (rval[g]),
      .ext_val (ext_in),
      .bus     (opnd[g])
    );
  end

  uop_alu #(.DW(DW)) u_alu (
    .op    (cw.op),
    .a     (opnd[0]),
    .b     (opnd[1]),
    .res   (alu_res),
    .zero  (alu_z),
    .sign  (alu_s),
    .carry (alu_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_out    <= '0;
      flag_zero  <= 1'b1;
      flag_sign  <= 1'b0;
      flag_carry <= 1'b0;
    end else begin
      ext_out    <= alu_res;
      flag_zero  <= alu_z;
      flag_sign  <= alu_s;
      flag_carry <= alu_c;
    end
  end
endmodule

// File: rtl/uop_datapath_chk.sv
module uop_datapath_chk
  import uop_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [CW_W-1:0] ctrl_word,
  input logic [DW-1:0]   ext_in,
  input logic [DW-1:0]   ext_out,
  input logic            flag_zero,
  input logic            flag_sign,
  input logic            flag_carry
);
  logic [SEL_W-1:0] sa;
  logic [OP_W-1:0]  op;
  logic             known_op, no_carry_op;

  assign sa = ctrl_word[CW_W-1 -: SEL_W];
  assign op = ctrl_word[OP_W-1:0];
  assign known_op = op inside {OP_XFER, OP_ADD, OP_SUB, OP_AND, OP_OR,
                               OP_XOR, OP_NOTA, OP_SHR, OP_SHL};
  assign no_carry_op = op inside {OP_XFER, OP_AND, OP_OR, OP_XOR, OP_NOTA};

  assert_reset_values_R11: assert property (@(posedge clk)
    rst |=> (ext_out == '0 && flag_zero && !flag_sign && !flag_carry));

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
    flag_zero == (ext_out == '0));

  assert_sign_flag_R10: assert property (@(posedge clk) disable iff (rst)
    flag_sign == ext_out[DW-1]);

  assert_ext_transfer_R3: assert property (@(posedge clk) disable iff (rst)
    (sa == '0 && op == OP_XFER) |=> ext_out == $past(ext_in));

  assert_ext_complement_R7: assert property (@(posedge clk) disable iff (rst)
    (sa == '0 && op == OP_NOTA) |=> ext_out == ~$past(ext_in));

  assert_logic_no_carry_R7: assert property (@(posedge clk) disable iff (rst)
    no_carry_op |=> !flag_carry);

  assert_shift_right_R8: assert property (@(posedge clk) disable iff (rst)
    (sa == '0 && op == OP_SHR) |=>
      (ext_out == ($past(ext_in) >> 1) && flag_carry == $past(ext_in[0])));

  assert_shift_left_R8: assert property (@(posedge clk) disable iff (rst)
    (sa == '0 && op == OP_SHL) |=>
      (ext_out == ($past(ext_in) << 1) && flag_carry == $past(ext_in[DW-1])));

  assert_undefined_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (sa == '0 && !known_op) |=> (ext_out == $past(ext_in) && !flag_carry));
endmodule

bind uop_datapath uop_datapath_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_word  (ctrl_word),
  .ext_in     (ext_in),
  .ext_out    (ext_out),
  .flag_zero  (flag_zero),
  .flag_sign  (flag_sign),
  .flag_carry (flag_carry)
);

// File: tb/sim_uop_datapath.sv
`timescale 1ns/1ps
module sim_uop_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  ext_out;
  logic        flag_zero, flag_sign, flag_carry;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] m [8];

  always #5 clk = ~clk;

  uop_datapath u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
    .ext_out(ext_out), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_carry(flag_carry)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // arithmetic reference, returns {carry, result}
  function automatic logic [8:0] ref_alu(input logic [4:0] op,
                                         input logic [7:0] a, input logic [7:0] b);
    int s;
    case (op)
      5'b00010: begin s = int'(a) + int'(b); return {s > 255, 8'(s)}; end
      5'b00101: begin s = int'(a) - int'(b); return {a < b, 8'(s)}; end
      5'b01000: return {1'b0, a & b};
      5'b01010: return {1'b0, a | b};
      5'b01100: return {1'b0, a ^ b};
      5'b01110: return {1'b0, 8'(255 - int'(a))};
      5'b10000: return {a[0], 8'(a / 2)};
      5'b11000: return {a[7], 8'((int'(a) * 2) % 256)};
      default:  return {1'b0, a};
    endcase
  endfunction

  function automatic string op_tag(input logic [4:0] op);
    case (op)
      5'b00010, 5'b00101: return "R6";
      5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b00000: return "R7";
      5'b10000, 5'b11000: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic [2:0] sa, input logic [2:0] sb,
                      input logic [2:0] sd, input logic [4:0] op,
                      input logic [7:0] ex, input string tag);
    logic [7:0] a, b;
    logic [8:0] r;
    a = (sa == 0) ? ex : m[sa];
    b = (sb == 0) ? ex : m[sb];
    r = ref_alu(op, a, b);
    @(negedge clk);
    ctrl_word = {sa, sb, sd, op};  // R1 field order
    ext_in    = ex;
    @(posedge clk);
    #1;
    if (sd != 0) m[sd] = r[7:0];
    check(tag, int'(ext_out), int'(r[7:0]));
    check({tag, "/R10"}, int'({flag_zero, flag_sign, flag_carry}),
          int'({r[7:0] == 8'h00, r[7], r[8]}));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    check("R11", int'({ext_out, flag_zero, flag_sign, flag_carry}), int'({8'h00, 3'b100}));
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R11", int'({ext_out, flag_zero, flag_sign, flag_carry}), int'({8'h00, 3'b100}));
    @(negedge clk);
    rst = 1'b0;

    // R11: registers read back zero after reset
    for (int k = 1; k < 8; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'hA5, "R11");

    // R3/R4/R5: load each register from the external input
    for (int k = 1; k < 8; k++) step(3'd0, 3'd0, 3'(k), 5'b00000, 8'(k * 37 + 5), "R3");
    // R2: read each back
    for (int k = 1; k < 8; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, "R2");

    // R6: word 010 011 001 00010 (R1 = R2 + R3), then read R1
    step(3'd2, 3'd3, 3'd1, 5'b00010, 8'h00, "R6");
    step(3'd1, 3'd0, 3'd0, 5'b00000, 8'h00, "R4");
    // R6: word 010 011 001 00101 (R1 = R2 - R3), borrow case
    step(3'd2, 3'd3, 3'd1, 5'b00101, 8'h00, "R6");
    step(3'd3, 3'd2, 3'd1, 5'b00101, 8'h00, "R6");

    // R4/R5: destination 0 shows the result but writes nothing
    step(3'd0, 3'd5, 3'd0, 5'b01100, 8'h3C, "R5");
    for (int k = 1; k < 8; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, "R4");

    // R12: same register as both sources and destination
    step(3'd4, 3'd4, 3'd4, 5'b00010, 8'h00, "R12");
    step(3'd4, 3'd0, 3'd0, 5'b00000, 8'h00, "R12");
    step(3'd6, 3'd6, 3'd6, 5'b11000, 8'h00, "R12");
    step(3'd6, 3'd0, 3'd0, 5'b00000, 8'h00, "R12");

    // R6-R9: boundary values from the external input
    step(3'd0, 3'd0, 3'd0, 5'b00010, 8'hFF, "R6");
    step(3'd0, 3'd0, 3'd0, 5'b00101, 8'h80, "R6");
    step(3'd0, 3'd0, 3'd0, 5'b10000, 8'h01, "R8");
    step(3'd0, 3'd0, 3'd0, 5'b11000, 8'h80, "R8");
    step(3'd0, 3'd0, 3'd0, 5'b11111, 8'h9E, "R9");

    // full sweep of operation x source A x source B x destination
    for (int op = 0; op < 32; op++)
      for (int sa = 0; sa < 8; sa++)
        for (int sb = 0; sb < 8; sb++)
          for (int sd = 0; sd < 8; sd++)
            step(3'(sa), 3'(sb), 3'(sd), 5'(op),
                 8'(op * 53 + sa * 17 + sb * 5 + sd * 3 + 1), op_tag(5'(op)));

    // R11: reset in mid-run clears the register file
    do_reset();
    for (int k = 1; k < 8; k++) step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, "R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule